// File: doc/BRIEF.md
# Configure Command Sequencer

This block carries out the configure action command of a network controller's command unit. Once a command is accepted, it fetches the configuration block from host memory one byte at a time through a simple request/return read port. The eight leading bytes are kept in local registers and are visible on a flat output bus. The sequencer then places a command marker in the transmit FIFO. The remaining bytes follow through the same FIFO to the execution engine that owns the other configuration registers.

The sequencer then waits for the engine to acknowledge that it has finished its internal update. It writes a single status word with the complete and OK flags set, and returns to idle. The byte count that comes with the command is capped at twenty-two bytes. A `busy` flag covers the whole command. Commands that arrive while `busy` is high are dropped.

Top module: `cfg_cmd_seq`

## Requirements
- R1: `cmd_valid` sampled high while idle is accepted, and `busy` is high from the next cycle. It stays high through the cycle in which `st_we` is high and is low in the cycle after.
- R2: The first host reads go to `cmd_base+0` through `cmd_base+7`, in ascending order. Each returned byte k appears on `cfg_local[8k+7:8k]`. These eight bytes are always read, whatever the count.
- R3: The first FIFO entry of a command is the marker: bit 8 set to 1, and bits 7:0 holding the number of remainder bytes that follow. No data entry precedes it.
- R4: After the marker, each remainder byte is read from `cmd_base+8+i` and pushed in ascending order with bit 8 set to 0.
- R5: The effective length is min(`cmd_count`, 22), so the remainder is min(`cmd_count`, 22) − 8. Any larger count is truncated.
- R6: A count of 8 or less gives a marker with count 0 and no data entries. The block still waits for the engine acknowledgement.
- R7: While `fifo_valid` is high and `fifo_ready` is low, `fifo_valid` stays high and `fifo_data` stays unchanged. No entry is lost or duplicated.
- R8: `eng_done` counts only after the last FIFO entry has been accepted. `st_we` goes high only in the cycle after such an acknowledgement, and a pulse that arrives earlier has no effect.
- R9: Each command produces exactly one `st_we` pulse of one cycle. The value is `st_word` = 16'hA000, with the complete bit 15 set, the OK bit 13 set and all other bits zero.
- R10: `cmd_valid` while busy is ignored. The running command's reads and FIFO entries keep its own base and count, and no second sequence starts after it.
- R11: At most one host read is outstanding. `rd_req` is a single-cycle pulse and is not raised again until `rd_valid` has returned the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Configure command request |
| cmd_base | input | 32 | Host address of configuration byte 0 |
| cmd_count | input | 8 | Requested configuration length in bytes |
| busy | output | 1 | Command in progress |
| rd_req | output | 1 | One-cycle host read request |
| rd_addr | output | 32 | Byte address of the read |
| rd_valid | input | 1 | Read data return strobe |
| rd_data | input | 8 | Returned byte |
| cfg_local | output | 64 | Locally held bytes 0..7, byte k at bits 8k+7:8k |
| fifo_valid | output | 1 | Transmit FIFO entry valid |
| fifo_ready | input | 1 | Transmit FIFO can accept |
| fifo_data | output | 9 | Bit 8 marker flag, bits 7:0 count or data byte |
| eng_done | input | 1 | Execution engine update-complete acknowledgement |
| st_we | output | 1 | Status word write strobe |
| st_word | output | 16 | Status word, valid with st_we |

## Verification
The assertions assume a well-behaved host port: `rd_valid` is raised only while a read is outstanding, and then once per request. The bench's memory model answers each request exactly once, after one to three cycles. The assertions also assume that the engine holds `eng_done` until it sees the status write. The bench's engine model raises it only after it has counted the full remainder out of the FIFO, apart from a deliberate early one-cycle pulse used to exercise R8. FIFO back-pressure is random, and a seeded random command mix covers counts from 0 to 40, together with directed lengths at 0, 8, 9, 22, 23 and 255.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_LREQ, S_LWAIT, S_MARK, S_RREQ, S_RWAIT, S_RPUSH, S_ACK, S_STAT
  } seq_state_e;

  localparam int STATUS_W    = 16;
  localparam int STAT_C_BIT  = 15;
  localparam int STAT_OK_BIT = 13;

  // Effective length after the cap.
  function automatic int unsigned clamp_len(int unsigned req, int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction

  // Bytes left after the locally held head.
  function automatic int unsigned tail_len(int unsigned eff, int unsigned head);
    return (eff > head) ? (eff - head) : 0;
  endfunction

  // Offset of the byte addressed by the counter in either phase.
  function automatic int unsigned byte_offset(int unsigned ctr, logic tail, int unsigned head);
    return tail ? (head + ctr) : ctr;
  endfunction

  function automatic logic [STATUS_W-1:0] done_status();
    logic [STATUS_W-1:0] w;
    w = '0;
    w[STAT_C_BIT]  = 1'b1;
    w[STAT_OK_BIT] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/cfg_byte_ctr.sv
module cfg_byte_ctr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/cfg_local_store.sv
module cfg_local_store #(
  parameter int NB = 8,
  parameter int DW = 8,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [IW-1:0]  idx,
  input  logic [DW-1:0]  din,
  output logic [NB*DW-1:0] flat
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [DW-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        r <= '0;
      else if (we && (idx == IW'(g)))    r <= din;
    end
    assign flat[g*DW +: DW] = r;
  end
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic rd_valid,
  input  logic fifo_ready,
  input  logic eng_done,
  input  logic last_local,
  input  logic last_tail,
  input  logic tail_zero,
  output logic busy,
  output logic rd_req,
  output logic tail_phase,
  output logic fifo_valid,
  output logic fifo_is_mark,
  output logic st_we,
  output logic ctr_clr,
  output logic ctr_inc,
  output logic local_we,
  output logic hold_we,
  output logic cmd_take,
  output logic ack_take
);
  seq_state_e st, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt          = st;
    rd_req       = 1'b0;
    tail_phase   = 1'b0;
    fifo_valid   = 1'b0;
    fifo_is_mark = 1'b0;
    st_we        = 1'b0;
    ctr_clr      = 1'b0;
    ctr_inc      = 1'b0;
    local_we     = 1'b0;
    hold_we      = 1'b0;
    cmd_take     = 1'b0;
    ack_take     = 1'b0;
    unique case (st)
      S_IDLE: if (cmd_valid) begin
        cmd_take = 1'b1;
        ctr_clr  = 1'b1;
        nxt      = S_LREQ;
      end
      S_LREQ: begin
        rd_req = 1'b1;
        nxt    = S_LWAIT;
      end
      S_LWAIT: if (rd_valid) begin
        local_we = 1'b1;
        if (last_local) nxt = S_MARK;
        else begin
          ctr_inc = 1'b1;
          nxt     = S_LREQ;
        end
      end
      S_MARK: begin
        fifo_valid   = 1'b1;
        fifo_is_mark = 1'b1;
        if (fifo_ready) begin
          ctr_clr = 1'b1;
          nxt     = tail_zero ? S_ACK : S_RREQ;
        end
      end
      S_RREQ: begin
        rd_req     = 1'b1;
        tail_phase = 1'b1;
        nxt        = S_RWAIT;
      end
      S_RWAIT: begin
        tail_phase = 1'b1;
        if (rd_valid) begin
          hold_we = 1'b1;
          nxt     = S_RPUSH;
        end
      end
      S_RPUSH: begin
        fifo_valid = 1'b1;
        if (fifo_ready) begin
          if (last_tail) nxt = S_ACK;
          else begin
            ctr_inc = 1'b1;
            nxt     = S_RREQ;
          end
        end
      end
      S_ACK: if (eng_done) begin
        ack_take = 1'b1;
        nxt      = S_STAT;
      end
      S_STAT: begin
        st_we = 1'b1;
        nxt   = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/cfg_cmd_seq.sv
module cfg_cmd_seq
  import cfg_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 8,
  parameter int DATA_W      = 8,
  parameter int LOCAL_BYTES = 8,
  parameter int MAX_BYTES   = 22
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  input  logic [ADDR_W-1:0]             cmd_base,
  input  logic [CNT_W-1:0]              cmd_count,
  output logic                          busy,
  output logic                          rd_req,
  output logic [ADDR_W-1:0]             rd_addr,
  input  logic                          rd_valid,
  input  logic [DATA_W-1:0]             rd_data,
  output logic [LOCAL_BYTES*DATA_W-1:0] cfg_local,
  output logic                          fifo_valid,
  input  logic                          fifo_ready,
  output logic [DATA_W:0]               fifo_data,
  input  logic                          eng_done,
  output logic                          st_we,
  output logic [STATUS_W-1:0]           st_word
);
  localparam int IDX_W = $clog2(MAX_BYTES + 1);
  localparam int LIDX  = (LOCAL_BYTES > 1) ? $clog2(LOCAL_BYTES) : 1;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  tail_q;
  logic [DATA_W-1:0] hold_q;
  logic [IDX_W-1:0]  ctr;

  // Named internal events, also used by the bound checker.
  logic cmd_take, ack_take;
  logic ctr_clr, ctr_inc, local_we, hold_we;
  logic tail_phase, fifo_is_mark;
  logic last_local, last_tail, tail_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      tail_q <= '0;
    end else if (cmd_take) begin
      base_q <= cmd_base;
      tail_q <= CNT_W'(tail_len(clamp_len(32'(cmd_count), MAX_BYTES), LOCAL_BYTES));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_we) hold_q <= rd_data;
  end

  assign last_local = (32'(ctr) == LOCAL_BYTES - 1);
  assign last_tail  = ((32'(ctr) + 1) == 32'(tail_q));
  assign tail_zero  = (tail_q == '0);

  cfg_byte_ctr #(.W(IDX_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .inc(ctr_inc), .q(ctr)
  );

  cfg_local_store #(.NB(LOCAL_BYTES), .DW(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(local_we), .idx(ctr[LIDX-1:0]),
    .din(rd_data), .flat(cfg_local)
  );

  cfg_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .rd_valid(rd_valid), .fifo_ready(fifo_ready),
    .eng_done(eng_done), .last_local(last_local), .last_tail(last_tail),
    .tail_zero(tail_zero), .busy(busy), .rd_req(rd_req),
    .tail_phase(tail_phase), .fifo_valid(fifo_valid),
    .fifo_is_mark(fifo_is_mark), .st_we(st_we), .ctr_clr(ctr_clr),
    .ctr_inc(ctr_inc), .local_we(local_we), .hold_we(hold_we),
    .cmd_take(cmd_take), .ack_take(ack_take)
  );

  assign rd_addr   = base_q + ADDR_W'(byte_offset(32'(ctr), tail_phase, LOCAL_BYTES));
  assign fifo_data = fifo_is_mark ? {1'b1, DATA_W'(tail_q)} : {1'b0, hold_q};
  assign st_word   = st_we ? done_status() : '0;
endmodule

// File: rtl/cfg_cmd_seq_chk.sv
module cfg_cmd_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cmd_take,
  input logic              ack_take,
  input logic              rd_req,
  input logic              rd_valid,
  input logic              fifo_valid,
  input logic              fifo_ready,
  input logic [DATA_W:0]   fifo_data,
  input logic              st_we,
  input logic [15:0]       st_word
);
  logic pend, mark_seen;
  wire  push = fifo_valid && fifo_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (rd_req)   pend <= 1'b1;
    else if (rd_valid) pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       mark_seen <= 1'b0;
    else if (cmd_take)                mark_seen <= 1'b0;
    else if (push && fifo_data[DATA_W]) mark_seen <= 1'b1;
  end

  // R1
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> busy);
  // R1
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> !busy);
  // R10
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |-> !busy);
  // R11
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !pend);
  // R7
  fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid && !fifo_ready) |=> (fifo_valid && $stable(fifo_data)));
  // R3
  mark_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !fifo_data[DATA_W]) |-> mark_seen);
  // R3
  mark_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fifo_data[DATA_W]) |-> !mark_seen);
  // R8
  status_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> $past(ack_take));
  // R9
  status_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> !st_we);
  // R9
  status_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (st_word == 16'hA000));
endmodule

bind cfg_cmd_seq cfg_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_take(cmd_take),
  .ack_take(ack_take), .rd_req(rd_req), .rd_valid(rd_valid),
  .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
  .st_we(st_we), .st_word(st_word)
);

// File: tb/tb_cfg_cmd_seq.sv
module tb_cfg_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_base = '0;
  logic [7:0]  cmd_count = '0;
  logic        busy, rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = '0;
  logic [63:0] cfg_local;
  logic        fifo_valid;
  logic        fifo_ready = 1'b0;
  logic [8:0]  fifo_data;
  logic        eng_done = 1'b0;
  logic        st_we;
  logic [15:0] st_word;

  always #2 clk = ~clk;

  cfg_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_base(cmd_base),
    .cmd_count(cmd_count), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .cfg_local(cfg_local),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
    .eng_done(eng_done), .st_we(st_we), .st_word(st_word)
  );

  int          checks = 0, errors = 0;
  logic [8:0]  fifo_q[$];
  logic [31:0] rd_q[$];
  int          st_cnt = 0;
  logic [15:0] st_last = '0;
  int          fifo_at_status = 0;
  logic        run_on = 1'b0;

  function automatic logic [7:0] memb(logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic int exp_tail(int cnt);
    int eff;
    eff = (cnt > 22) ? 22 : cnt;
    return (eff > 8) ? eff - 8 : 0;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Host memory model: one answer per request, 1..3 cycles later.
  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      #1;
      if (rd_req && run_on) begin
        logic [31:0] a;
        int k;
        a = rd_addr;
        k = $urandom % 3;
        repeat (k + 1) @(negedge clk);
        rd_data  = memb(a);
        rd_valid = 1'b1;
      end
    end
  end

  // FIFO sink and output monitor.
  initial begin
    forever begin
      @(negedge clk);
      fifo_ready = (($urandom % 10) < 7);
      #1;
      if (run_on) begin
        if (rd_req) rd_q.push_back(rd_addr);
        if (fifo_valid && fifo_ready) fifo_q.push_back(fifo_data);
        if (st_we) begin
          st_cnt++;
          st_last = st_word;
          fifo_at_status = fifo_q.size();
        end
      end
    end
  end

  // Execution engine model: acknowledges once the full remainder is out.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (run_on && busy && fifo_q.size() > 0 && st_cnt == 0 && !eng_done &&
          fifo_q.size() == 1 + int'(fifo_q[0][7:0])) begin
        repeat ($urandom % 4) @(negedge clk);
        eng_done = 1'b1;
        while (st_cnt == 0) begin
          @(negedge clk);
          #2;
        end
        eng_done = 1'b0;
      end
    end
  end

  task automatic run_cmd(logic [31:0] base, logic [7:0] cnt, bit intr, bit early);
    int tail, bad;
    fifo_q.delete();
    rd_q.delete();
    st_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_base  = base;
    cmd_count = cnt;
    @(negedge clk);
    cmd_valid = 1'b0;
    #2;
    chk(busy == 1'b1, "R1 busy after accept", busy, 1);
    if (early) begin
      @(negedge clk);
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
    end
    if (intr) begin
      repeat (2) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_base  = base ^ 32'h0000_1234;
      cmd_count = cnt + 8'd3;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (st_cnt == 0) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    #2;
    chk(busy == 1'b0, "R1 busy low after status", busy, 0);
    repeat (3) @(negedge clk);
    #2;
    chk(st_cnt == 1, "R9 one status write", st_cnt, 1);
    chk(st_last == 16'hA000, "R9 status word", st_last, 16'hA000);
    if (intr) chk(busy == 1'b0, "R10 no second sequence", busy, 0);

    tail = exp_tail(int'(cnt));
    chk(fifo_at_status == 1 + tail, "R8 status after full transfer", fifo_at_status, 1 + tail);
    chk(rd_q.size() == 8 + tail, "R5 read count", rd_q.size(), 8 + tail);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      if (i >= rd_q.size() || rd_q[i] != base + i) bad++;
      if (cfg_local[8*i +: 8] != memb(base + i)) bad++;
    end
    chk(bad == 0, "R2 head reads and local bytes", bad, 0);
    chk(fifo_q.size() == 1 + tail, "R4 fifo entry count", fifo_q.size(), 1 + tail);
    if (fifo_q.size() > 0)
      chk(fifo_q[0] == {1'b1, 8'(tail)}, "R3 marker entry", fifo_q[0], {1'b1, 8'(tail)});
    bad = 0;
    for (int i = 0; i < tail; i++) begin
      if (8 + i >= rd_q.size() || rd_q[8 + i] != base + 8 + i) bad++;
      if (1 + i >= fifo_q.size() || fifo_q[1 + i] != {1'b0, memb(base + 8 + i)}) bad++;
    end
    chk(bad == 0, "R4 remainder bytes in order", bad, 0);
    if (tail == 0) chk(fifo_q.size() == 1, "R6 no data after zero marker", fifo_q.size(), 1);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 1'b0 && rd_req == 1'b0 && fifo_valid == 1'b0 && st_we == 1'b0,
        "R1 reset outputs idle", {busy, rd_req, fifo_valid, st_we}, 0);
    chk(cfg_local == 64'd0, "R2 reset local bytes", cfg_local, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_on = 1'b1;

    run_cmd(32'h0000_1000, 8'd0,   1'b0, 1'b0);  // R6
    run_cmd(32'h0000_2040, 8'd8,   1'b0, 1'b0);  // R6
    run_cmd(32'h0000_3003, 8'd9,   1'b0, 1'b0);  // R4
    run_cmd(32'h0000_4100, 8'd22,  1'b0, 1'b0);  // R5
    run_cmd(32'h0000_50F0, 8'd23,  1'b0, 1'b0);  // R5
    run_cmd(32'h0000_6077, 8'd255, 1'b0, 1'b0);  // R5
    run_cmd(32'h0000_7010, 8'd16,  1'b1, 1'b0);  // R10
    run_cmd(32'h0000_8020, 8'd12,  1'b0, 1'b1);  // R8 early acknowledgement
    run_cmd(32'h0000_9000, 8'd4,   1'b0, 1'b1);  // R8 with R6
    for (int n = 0; n < 30; n++) begin
      run_cmd({16'h0, 16'($urandom)}, 8'($urandom % 41), 1'b0, 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule